// File: doc/BRIEF.md
# SPI Interrupt Status and Soft-Reset Unit

This block sits beside an SPI core and turns the core's single-cycle event pulses into sticky status bits that software reads and acknowledges over a simple 32-bit register bus. Each source has its own enable bit, and one global gate bit qualifies the combined result. Together they drive one level-sensitive interrupt line. Status bits record events whether or not any enable is set, so software that turns on interrupts late can find old events still pending. Software clears those first by writing back the value it read.

The same register window holds a soft-reset register. A write of the exact key value `0x0000000A` starts a fixed-length reset pulse to the attached core. The pulse also wipes the status and per-source enable registers. Any other value written there does nothing. The reset pulse is sequenced by a two-state machine. In state `RS_IDLE` it waits. The transition *key-accepted* (a key write in `RS_IDLE`) moves it to `RS_ACTIVE`, which drives the core reset and counts down. The transition *pulse-done* (count reaches zero) returns it to `RS_IDLE`.

The bus has a write strobe, a byte address, write data, and combinational read data for the address presented. The register offsets are fixed, because software decodes them: global gate at `0x1C`, status at `0x20`, per-source enable at `0x28`, soft reset at `0x40`.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After the asynchronous reset, the status, enable and global-gate registers read 0, and `irq_o` and `core_rst_o` are low.
- R2: A high cycle on `evt_i[k]` sets status bit k (readable at offset 0x20) from the next clock edge onward, whatever the enable and gate settings. Bit meanings: 0 mode fault, 1 slave-mode fault, 2 TX empty, 3 TX underrun, 4 RX full, 5 RX overrun, 6 TX half empty.
- R3: A write to offset 0x20 clears every status bit whose write-data bit is 1. Bits written 0 keep their value, so writing back a value just read clears exactly those bits.
- R4: If an event on source k arrives in the same cycle as a write-one-to-clear of bit k, bit k stays set.
- R5: `irq_o` is high exactly when (status AND enable) is non-zero and the global gate bit is set. Only bit 31 of offset 0x1C is stored, and it reads back in bit 31 with all other bits 0.
- R6: Offset 0x28 stores write-data bits [6:0] as per-source enables and reads them back in bits [6:0], with the upper bits 0.
- R7: A write of 0x0000000A to offset 0x40 drives `core_rst_o` high for exactly RST_CYCLES (default 4) consecutive cycles, starting right after the write's clock edge.
- R8: A write of any other value to offset 0x40 is ignored: `core_rst_o` stays low and status and enable keep their values.
- R9: While `core_rst_o` is high, status and enable are forced to 0 and events are not latched. The global gate bit keeps its value.
- R10: Reads of offset 0x40 and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| evt_i | input | NUM_SRC | Event pulses from the SPI core |
| irq_o | output | 1 | Level-sensitive interrupt |
| core_rst_o | output | 1 | Reset pulse to the attached core |

## Verification
The bench targets the cycle where an event and an acknowledge of the same bit coincide. A design that gives the clear priority would silently lose that event. It checks that status latches while the global gate is off and that the line rises only once the gate is set. A design that gated latching rather than the output would drop pending events or raise the line early. Near-miss key values are written to the reset register: a decoder that compares too few bits would fire a reset. The length of the reset pulse is counted, and events are injected during the pulse. An off-by-one counter, or a design that lets events or old enables survive the pulse, shows up as a wrong count or non-zero readback.

// File: rtl/spi_irq_pkg.sv
`timescale 1ns/1ps
package spi_irq_pkg;
    localparam int unsigned OFS_GIE  = 32'h1C;
    localparam int unsigned OFS_STAT = 32'h20;
    localparam int unsigned OFS_ENA  = 32'h28;
    localparam int unsigned OFS_SRST = 32'h40;
    localparam logic [31:0] SRST_KEY = 32'h0000_000A;
    localparam int GIE_BIT = 31;

    localparam int SRC_MODE_FAULT  = 0;
    localparam int SRC_SLV_FAULT   = 1;
    localparam int SRC_TX_EMPTY    = 2;
    localparam int SRC_TX_UNDERRUN = 3;
    localparam int SRC_RX_FULL     = 4;
    localparam int SRC_RX_OVERRUN  = 5;
    localparam int SRC_TX_HALF     = 6;

    typedef enum logic [0:0] {
        RS_IDLE   = 1'b0,
        RS_ACTIVE = 1'b1
    } rst_state_e;
endpackage

// File: rtl/irq_status_bank.sv
`timescale 1ns/1ps
module irq_status_bank #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               flush_i,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               clr_we_i,
    input  logic [NUM_SRC-1:0] clr_mask_i,
    output logic [NUM_SRC-1:0] status_o
);
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                bit_q <= 1'b0;
            end else if (flush_i) begin
                bit_q <= 1'b0;
            end else if (evt_i[k]) begin
                bit_q <= 1'b1;
            end else if (clr_we_i && clr_mask_i[k]) begin
                bit_q <= 1'b0;
            end
        end
        assign status_o[k] = bit_q;
    end
endmodule

// File: rtl/soft_reset_fsm.sv
`timescale 1ns/1ps
module soft_reset_fsm
    import spi_irq_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic key_hit_i,
    output logic active_o
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    rst_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        active_o = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
                if (key_hit_i) begin
                    state_d = RS_ACTIVE;
                    cnt_d   = CW'(RST_CYCLES - 1);
                end
            end
            RS_ACTIVE: begin
                active_o = 1'b1;
                if (cnt_q == '0) begin
                    state_d = RS_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end
endmodule

// File: rtl/irq_gate.sv
`timescale 1ns/1ps
module irq_gate #(
    parameter int NUM_SRC = 7
) (
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] enable_i,
    input  logic               gie_i,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] pend;
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_pend
        assign pend[k] = status_i[k] & enable_i[k];
    end
    assign irq_o = gie_i & (|pend);
endmodule

// File: rtl/spi_irq_ctrl.sv
`timescale 1ns/1ps
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_SRC    = 7,
    parameter int RST_CYCLES = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic               irq_o,
    output logic               core_rst_o
);
    logic               hit_gie, hit_stat, hit_ena, hit_srst;
    logic               gie_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] status_q;
    logic               key_hit;

    assign hit_gie  = (bus_addr_i == ADDR_W'(OFS_GIE));
    assign hit_stat = (bus_addr_i == ADDR_W'(OFS_STAT));
    assign hit_ena  = (bus_addr_i == ADDR_W'(OFS_ENA));
    assign hit_srst = (bus_addr_i == ADDR_W'(OFS_SRST));
    assign key_hit  = bus_wr_i && hit_srst && (bus_wdata_i == SRST_KEY);

    soft_reset_fsm #(.RST_CYCLES(RST_CYCLES)) u_srst (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .key_hit_i (key_hit),
        .active_o  (core_rst_o)
    );

    irq_status_bank #(.NUM_SRC(NUM_SRC)) u_stat (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .flush_i    (core_rst_o),
        .evt_i      (evt_i),
        .clr_we_i   (bus_wr_i && hit_stat),
        .clr_mask_i (bus_wdata_i[NUM_SRC-1:0]),
        .status_o   (status_q)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            enable_q <= '0;
        end else if (core_rst_o) begin
            enable_q <= '0;
        end else if (bus_wr_i && hit_ena) begin
            enable_q <= bus_wdata_i[NUM_SRC-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gie_q <= 1'b0;
        end else if (bus_wr_i && hit_gie) begin
            gie_q <= bus_wdata_i[GIE_BIT];
        end
    end

    irq_gate #(.NUM_SRC(NUM_SRC)) u_gate (
        .status_i (status_q),
        .enable_i (enable_q),
        .gie_i    (gie_q),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (hit_gie) begin
            bus_rdata_o[GIE_BIT] = gie_q;
        end else if (hit_stat) begin
            bus_rdata_o[NUM_SRC-1:0] = status_q;
        end else if (hit_ena) begin
            bus_rdata_o[NUM_SRC-1:0] = enable_q;
        end
    end
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
`timescale 1ns/1ps
module spi_irq_ctrl_chk
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_SRC = 7
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               bus_wr_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [31:0]        bus_wdata_i,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               irq_o,
    input logic               core_rst_o,
    input logic               gie_q,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q
);
    logic wr_stat, wr_srst;
    assign wr_stat = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_STAT));
    assign wr_srst = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_SRST));

    AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|evt_i) && !core_rst_o) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R2

    AST_W1C_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stat |=> ((status_q & $past(bus_wdata_i[NUM_SRC-1:0]) & ~$past(evt_i)) == '0)); // R3

    AST_IRQ_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gie_q |-> !irq_o); // R5

    AST_IRQ_HAS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (|(status_q & enable_q))); // R5

    AST_KEY_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_srst && bus_wdata_i == SRST_KEY && !core_rst_o) |=> core_rst_o); // R7

    AST_BAD_KEY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_srst && bus_wdata_i != SRST_KEY && !core_rst_o) |=> !core_rst_o); // R8

    AST_RST_WIPES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_rst_o |=> (status_q == '0 && enable_q == '0)); // R9
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .evt_i       (evt_i),
    .irq_o       (irq_o),
    .core_rst_o  (core_rst_o),
    .gie_q       (gie_q),
    .status_q    (status_q),
    .enable_q    (enable_q)
);

// File: tb/sim_spi_irq_ctrl.sv
`timescale 1ns/1ps
module sim_spi_irq_ctrl;
    localparam int ADDR_W = 8;
    localparam int NS     = 7;
    localparam int RSTC   = 4;
    localparam logic [7:0] A_GIE = 8'h1C, A_STAT = 8'h20, A_ENA = 8'h28, A_SRST = 8'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NS-1:0] evt = '0;
    logic irq, core_rst;
    int checks = 0;
    int errs = 0;

    always #10 clk = ~clk;

    spi_irq_ctrl #(.ADDR_W(ADDR_W), .NUM_SRC(NS), .RST_CYCLES(RSTC)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_i(evt),
        .irq_o(irq), .core_rst_o(core_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [NS-1:0] m);
        @(negedge clk);
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(A_GIE, v);  chk("R1 gie", v, 0);
        bus_read(A_STAT, v); chk("R1 status", v, 0);
        bus_read(A_ENA, v);  chk("R1 enable", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 core_rst", {31'b0, core_rst}, 0);
        bus_read(A_SRST, v); chk("R10 srst read", v, 0);
        bus_read(8'h10, v);  chk("R10 unmapped read", v, 0);
    endtask

    task automatic t_latch();
        logic [31:0] v;
        pulse(7'h04);
        bus_read(A_STAT, v); chk("R2 tx empty latched", v, 32'h04);
        chk("R5 no irq with gate off", {31'b0, irq}, 0);
        pulse(7'h41);
        bus_read(A_STAT, v); chk("R2 bits 0 and 6 latched", v, 32'h45);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        bus_write(A_STAT, 32'h04);
        bus_read(A_STAT, v); chk("R3 clear bit2", v, 32'h41);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, v); chk("R3 zero write keeps", v, 32'h41);
        bus_write(A_STAT, v);
        bus_read(A_STAT, v); chk("R3 write-back clears all", v, 0);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        bus_write(A_ENA, 32'hFFFF_FFFF);
        bus_read(A_ENA, v); chk("R6 enable readback", v, 32'h7F);
        bus_write(A_ENA, 32'h10);
        pulse(7'h10);
        chk("R5 gate off blocks", {31'b0, irq}, 0);
        bus_write(A_GIE, 32'h8000_0000);
        bus_read(A_GIE, v); chk("R5 gate readback", v, 32'h8000_0000);
        chk("R5 irq asserted", {31'b0, irq}, 1);
        bus_write(A_GIE, 32'h7FFF_FFFF);
        bus_read(A_GIE, v); chk("R5 only bit31 stored", v, 0);
        chk("R5 irq off with gate clear", {31'b0, irq}, 0);
        bus_write(A_GIE, 32'h8000_0000);
        bus_write(A_ENA, 32'h01);
        chk("R5 disabled source no irq", {31'b0, irq}, 0);
        bus_write(A_ENA, 32'h10);
        chk("R5 re-enabled source irq", {31'b0, irq}, 1);
        bus_write(A_STAT, 32'h7F);
        chk("R5 irq drops after ack", {31'b0, irq}, 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        pulse(7'h08);
        @(negedge clk);
        evt = 7'h08; wr = 1'b1; addr = A_STAT; wdata = 32'h08;
        @(negedge clk);
        evt = '0; wr = 1'b0; wdata = '0;
        bus_read(A_STAT, v); chk("R4 event wins over clear", v, 32'h08);
        bus_write(A_STAT, 32'h08);
        bus_read(A_STAT, v); chk("R4 later clear works", v, 0);
    endtask

    task automatic t_badkey();
        logic [31:0] v;
        int hi = 0;
        pulse(7'h22);
        bus_write(A_ENA, 32'h22);
        bus_write(A_SRST, 32'h0000_000B);
        if (core_rst) hi++;
        bus_write(A_SRST, 32'h0000_010A);
        if (core_rst) hi++;
        bus_write(A_SRST, 32'h8000_000A);
        for (int i = 0; i < RSTC + 2; i++) begin
            if (core_rst) hi++;
            @(negedge clk);
        end
        chk("R8 no reset on bad key", hi, 0);
        bus_read(A_STAT, v); chk("R8 status kept", v, 32'h22);
        bus_read(A_ENA, v);  chk("R8 enable kept", v, 32'h22);
    endtask

    task automatic t_softreset();
        logic [31:0] v;
        int hi = 0;
        int first = 0;
        bus_write(A_SRST, 32'h0000_000A);
        first = core_rst;
        for (int i = 0; i < RSTC + 4; i++) begin
            if (core_rst) hi++;
            if (i == 1) evt = 7'h7F;
            if (i == 2) evt = '0;
            @(negedge clk);
        end
        chk("R7 reset starts next cycle", first, 1);
        chk("R7 reset length", hi, RSTC);
        bus_read(A_STAT, v); chk("R9 status wiped", v, 0);
        bus_read(A_ENA, v);  chk("R9 enable wiped", v, 0);
        bus_read(A_GIE, v);  chk("R9 gate kept", v, 32'h8000_0000);
        chk("R9 irq low after reset", {31'b0, irq}, 0);
        pulse(7'h01);
        bus_read(A_STAT, v); chk("R2 latch after soft reset", v, 32'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_w1c();
        t_gate();
        t_collide();
        t_badkey();
        t_softreset();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule